// File: doc/BRIEF.md
# Memory-side vector add sequencer

This block sits beside a memory controller's transaction queue and carries out simple array arithmetic near DRAM, so the host does not have to move the arrays across its bus. The host sends three kinds of command. A memory load fills one register from DRAM. An immediate load writes a constant into a register. A vector add sums two arrays element by element into a third array. The sequencer keeps a small register file. Each entry holds a data word, a base address and a status flag: unused, waiting or full. It emits read and write requests to the queue and takes read responses back.

For an add, the sequencer reads the element count from the data field of a named size register. For element i it issues a read from each source base plus i. It waits until both sources turn full, then forms the sum in the destination entry and issues the write of that sum. The reads for element i+1 go out straight after that write. Commands are accepted with a valid/ready pair. Requests leave through a valid/ready pair. Responses come back tagged and are always accepted.

Control states: IDLE (takes commands), LD_REQ (memory-load read offered), LD_WAIT (memory-load response pending), RD_A and RD_B (source reads offered), SUM (waits for both sources to be full), WR (write offered). Transitions: IDLE to LD_REQ when a memory load is taken. LD_REQ to LD_WAIT when the read is accepted. LD_WAIT to IDLE when the load response arrives. IDLE to RD_A when an add with a non-zero count is taken. RD_A to RD_B to SUM, each on acceptance. SUM to WR once both sources are full. WR to RD_A when the write is accepted and elements remain. WR to IDLE when the last write is accepted. An add with a count of zero stays in IDLE.

Top module: `mem_vadd_seq`

## Requirements
- R1: After reset `unit_state` is open (0), `req_valid` is low, and `cmd_ready` is high for a memory-load or add command.
- R2: A memory load (`cmd_op`=0) issues exactly one read, with tag 0, at address `cmd_imm + cmd_ofs`. `cmd_ready` stays low for loads and adds until the tagged-0 response has arrived.
- R3: An immediate load (`cmd_op`=1) writes `cmd_imm` into the register and issues no request. Its value serves as an add's element count.
- R4: An add (`cmd_op`=2) with count n issues, for each i from 0 to n-1 in order, three requests. First a read at source-1 base+i with tag 1. Then a read at source-2 base+i with tag 2. Then a write at destination base+i, with tag 0, of the sum of the two returned words.
- R5: The sum wraps modulo 2^DATA_W.
- R6: An add whose count is zero issues no request. `unit_state` becomes free (2) and `cmd_ready` is high in the cycle after acceptance.
- R7: `unit_state` reads occupied (1) from the cycle after a non-zero add is accepted. It becomes free (2) in the cycle after the last write is accepted, and never returns to open.
- R8: While an add runs, `cmd_ready` is low for memory-load and add commands and high for immediate loads.
- R9: A request held off by a low `req_ready` keeps `req_valid` high and its address, data, direction and tag unchanged until it is accepted.
- R10: Read responses are steered by tag (1 to source 1, 2 to source 2), so a source-2 response that arrives before the source-1 response still gives the correct sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken when high together with cmd_valid |
| cmd_op | input | 2 | 0 memory load, 1 immediate load, 2 add |
| cmd_rd | input | IDX_W | Destination register |
| cmd_rs1 | input | IDX_W | First source register (add) |
| cmd_rs2 | input | IDX_W | Second source register (add) |
| cmd_rsz | input | IDX_W | Register holding the element count (add) |
| cmd_imm | input | DATA_W | Immediate value, or host register value for a memory load |
| cmd_ofs | input | ADDR_W | Address offset for a memory load |
| req_valid | output | 1 | Request offered to the transaction queue |
| req_ready | input | 1 | Queue accepts the request |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | ADDR_W | Request address |
| req_wdata | output | DATA_W | Write data |
| req_tag | output | 2 | Read tag: 0 load, 1 source 1, 2 source 2 |
| rsp_valid | input | 1 | Read response present |
| rsp_tag | input | 2 | Tag of the response |
| rsp_data | input | DATA_W | Read data |
| unit_state | output | 2 | 0 open, 1 occupied, 2 free |

## Verification
The properties rest on several assumptions about the environment. A response arrives only for a read that is still outstanding, with that read's tag, and at most one arrives per cycle. `cmd_op` is never 3. An immediate load issued during an add does not name one of the add's four registers. Source and destination registers are distinct, and the three arrays do not overlap in memory. The stimulus keeps to these rules: its memory model answers only accepted reads, after a latency set per tag. During an add it writes only to a spare register. It uses separate address regions for the sources and the destination. It varies response order and queue backpressure across runs.

// File: rtl/mvs_pkg.sv
package mvs_pkg;

    typedef enum logic [1:0] {
        ST_UNUSED = 2'd0,
        ST_WAIT   = 2'd1,
        ST_FULL   = 2'd2
    } rstat_e;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_LOADI = 2'd1,
        OP_ADD   = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        U_OPEN = 2'd0,
        U_BUSY = 2'd1,
        U_FREE = 2'd2
    } unit_e;

    localparam logic [1:0] TAG_LD   = 2'd0;
    localparam logic [1:0] TAG_SRC1 = 2'd1;
    localparam logic [1:0] TAG_SRC2 = 2'd2;

endpackage

// File: rtl/mvs_regfile.sv
module mvs_regfile #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int NREG   = 8,
    parameter int NPORT  = 4,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NPORT-1:0]                  wp_en,
    input  logic [NPORT-1:0][IDX_W-1:0]       wp_idx,
    input  logic [NPORT-1:0]                  wp_dwe,
    input  logic [NPORT-1:0][DATA_W-1:0]      wp_data,
    input  logic [NPORT-1:0]                  wp_awe,
    input  logic [NPORT-1:0][ADDR_W-1:0]      wp_addr,
    input  logic [NPORT-1:0]                  wp_swe,
    input  logic [NPORT-1:0][1:0]             wp_stat,
    output logic [NREG-1:0][DATA_W-1:0]       rf_data,
    output logic [NREG-1:0][ADDR_W-1:0]       rf_addr,
    output logic [NREG-1:0][1:0]              rf_stat
);
    import mvs_pkg::*;

    for (genvar e = 0; e < NREG; e++) begin : g_ent
        logic [DATA_W-1:0] data_q;
        logic [ADDR_W-1:0] addr_q;
        logic [1:0]        stat_q;

        // higher-numbered ports win when two hit the same entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q <= '0;
                addr_q <= '0;
                stat_q <= ST_UNUSED;
            end else begin
                for (int p = 0; p < NPORT; p++) begin
                    if (wp_en[p] && wp_idx[p] == IDX_W'(e)) begin
                        if (wp_dwe[p]) data_q <= wp_data[p];
                        if (wp_awe[p]) addr_q <= wp_addr[p];
                        if (wp_swe[p]) stat_q <= wp_stat[p];
                    end
                end
            end
        end

        assign rf_data[e] = data_q;
        assign rf_addr[e] = addr_q;
        assign rf_stat[e] = stat_q;
    end

endmodule

// File: rtl/mvs_steer.sv
module mvs_steer #(
    parameter int DATA_W = 16,
    parameter int NREG   = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_tag,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [IDX_W-1:0]  s1_idx,
    input  logic [IDX_W-1:0]  s2_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);
    import mvs_pkg::*;

    always_comb begin
        wr_data = rsp_data;
        wr_en   = rsp_valid;
        unique case (rsp_tag)
            TAG_LD:   wr_idx = ld_idx;
            TAG_SRC1: wr_idx = s1_idx;
            TAG_SRC2: wr_idx = s2_idx;
            default: begin
                wr_idx = ld_idx;
                wr_en  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mvs_ctrl.sv
module mvs_ctrl #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int NREG   = 8,
    localparam int IDX_W = $clog2(NREG),
    localparam int NP    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    output logic                          cmd_ready,
    input  logic [1:0]                    cmd_op,
    input  logic [IDX_W-1:0]              cmd_rd,
    input  logic [IDX_W-1:0]              cmd_rs1,
    input  logic [IDX_W-1:0]              cmd_rs2,
    input  logic [IDX_W-1:0]              cmd_rsz,
    input  logic [DATA_W-1:0]             cmd_imm,
    input  logic [ADDR_W-1:0]             cmd_ofs,
    output logic                          req_valid,
    input  logic                          req_ready,
    output logic                          req_write,
    output logic [ADDR_W-1:0]             req_addr,
    output logic [DATA_W-1:0]             req_wdata,
    output logic [1:0]                    req_tag,
    input  logic                          rsp_valid,
    input  logic [1:0]                    rsp_tag,
    output logic [1:0]                    unit_state,
    input  logic [NREG-1:0][DATA_W-1:0]   rf_data,
    input  logic [NREG-1:0][ADDR_W-1:0]   rf_addr,
    input  logic [NREG-1:0][1:0]          rf_stat,
    output logic [NP-1:0]                 wp_en,
    output logic [NP-1:0][IDX_W-1:0]      wp_idx,
    output logic [NP-1:0]                 wp_dwe,
    output logic [NP-1:0][DATA_W-1:0]     wp_data,
    output logic [NP-1:0]                 wp_awe,
    output logic [NP-1:0][ADDR_W-1:0]     wp_addr,
    output logic [NP-1:0]                 wp_swe,
    output logic [NP-1:0][1:0]            wp_stat,
    output logic [IDX_W-1:0]              ld_idx,
    output logic [IDX_W-1:0]              s1_idx,
    output logic [IDX_W-1:0]              s2_idx
);
    import mvs_pkg::*;

    typedef enum logic [2:0] {
        S_IDLE, S_LD_REQ, S_LD_WAIT, S_RD_A, S_RD_B, S_SUM, S_WR
    } state_e;

    state_e            st, nxt;
    unit_e             unit_q, unit_n;
    logic [IDX_W-1:0]  ld_q, rd_q, s1_q, s2_q;
    logic [ADDR_W-1:0] ld_addr_q;
    logic [DATA_W-1:0] size_q, ofs_q;

    logic              cmd_fire;
    logic [ADDR_W-1:0] ld_addr;
    logic [ADDR_W-1:0] ofs_a;
    logic [DATA_W-1:0] sum;
    logic              last_elem;

    assign cmd_fire  = cmd_valid && cmd_ready;
    assign ld_addr   = ADDR_W'(cmd_imm) + cmd_ofs;
    assign ofs_a     = ADDR_W'(ofs_q);
    assign sum       = rf_data[s1_q] + rf_data[s2_q];
    assign last_elem = (ofs_q + DATA_W'(1)) == size_q;

    assign unit_state = unit_q;
    assign ld_idx     = ld_q;
    assign s1_idx     = s1_q;
    assign s2_idx     = s2_q;

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            unit_q    <= U_OPEN;
            ld_q      <= '0;
            rd_q      <= '0;
            s1_q      <= '0;
            s2_q      <= '0;
            ld_addr_q <= '0;
            size_q    <= '0;
            ofs_q     <= '0;
        end else begin
            st     <= nxt;
            unit_q <= unit_n;
            if (cmd_fire && st == S_IDLE && cmd_op == OP_LOAD) begin
                ld_q      <= cmd_rd;
                ld_addr_q <= ld_addr;
            end
            if (cmd_fire && st == S_IDLE && cmd_op == OP_ADD) begin
                rd_q   <= cmd_rd;
                s1_q   <= cmd_rs1;
                s2_q   <= cmd_rs2;
                size_q <= rf_data[cmd_rsz];
                ofs_q  <= '0;
            end
            if (st == S_WR && req_ready) ofs_q <= ofs_q + DATA_W'(1);
        end
    end

    // next state and outputs
    always_comb begin
        nxt       = st;
        unit_n    = unit_q;
        cmd_ready = (st == S_IDLE) || (cmd_op == OP_LOADI);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        req_tag   = TAG_LD;
        wp_en     = '0;
        wp_idx    = '0;
        wp_dwe    = '0;
        wp_data   = '0;
        wp_awe    = '0;
        wp_addr   = '0;
        wp_swe    = '0;
        wp_stat   = '0;

        // port 0: command side
        if (cmd_fire) begin
            wp_en[0]  = 1'b1;
            wp_idx[0] = cmd_rd;
            wp_swe[0] = 1'b1;
            unique case (cmd_op)
                OP_LOADI: begin
                    wp_dwe[0]  = 1'b1;
                    wp_data[0] = cmd_imm;
                    wp_stat[0] = ST_FULL;
                end
                OP_LOAD: begin
                    wp_awe[0]  = 1'b1;
                    wp_addr[0] = ld_addr;
                    wp_stat[0] = ST_WAIT;
                    nxt        = S_LD_REQ;
                end
                OP_ADD: begin
                    wp_stat[0] = ST_UNUSED;
                    if (rf_data[cmd_rsz] == '0) begin
                        unit_n = U_FREE;
                    end else begin
                        unit_n = U_BUSY;
                        nxt    = S_RD_A;
                    end
                end
                default: wp_en[0] = 1'b0;
            endcase
        end

        unique case (st)
            S_IDLE: ;
            S_LD_REQ: begin
                req_valid = 1'b1;
                req_addr  = ld_addr_q;
                if (req_ready) nxt = S_LD_WAIT;
            end
            S_LD_WAIT: begin
                if (rsp_valid && rsp_tag == TAG_LD) nxt = S_IDLE;
            end
            S_RD_A: begin
                req_valid = 1'b1;
                req_addr  = rf_addr[s1_q] + ofs_a;
                req_tag   = TAG_SRC1;
                if (req_ready) begin
                    wp_en[1]   = 1'b1;
                    wp_idx[1]  = s1_q;
                    wp_swe[1]  = 1'b1;
                    wp_stat[1] = ST_WAIT;
                    nxt        = S_RD_B;
                end
            end
            S_RD_B: begin
                req_valid = 1'b1;
                req_addr  = rf_addr[s2_q] + ofs_a;
                req_tag   = TAG_SRC2;
                if (req_ready) begin
                    wp_en[2]   = 1'b1;
                    wp_idx[2]  = s2_q;
                    wp_swe[2]  = 1'b1;
                    wp_stat[2] = ST_WAIT;
                    nxt        = S_SUM;
                end
            end
            S_SUM: begin
                if (rf_stat[s1_q] == ST_FULL && rf_stat[s2_q] == ST_FULL) begin
                    wp_en[1]   = 1'b1;
                    wp_idx[1]  = rd_q;
                    wp_dwe[1]  = 1'b1;
                    wp_data[1] = sum;
                    wp_swe[1]  = 1'b1;
                    wp_stat[1] = ST_FULL;
                    nxt        = S_WR;
                end
            end
            S_WR: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_addr  = rf_addr[rd_q] + ofs_a;
                req_wdata = rf_data[rd_q];
                if (req_ready) begin
                    if (last_elem) begin
                        wp_en[1]   = 1'b1;
                        wp_idx[1]  = s1_q;
                        wp_swe[1]  = 1'b1;
                        wp_stat[1] = ST_UNUSED;
                        wp_en[2]   = 1'b1;
                        wp_idx[2]  = s2_q;
                        wp_swe[2]  = 1'b1;
                        wp_stat[2] = ST_UNUSED;
                        unit_n     = U_FREE;
                        nxt        = S_IDLE;
                    end else begin
                        nxt = S_RD_A;
                    end
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

endmodule

// File: rtl/mem_vadd_seq.sv
module mem_vadd_seq #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int NREG   = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_rd,
    input  logic [IDX_W-1:0]  cmd_rs1,
    input  logic [IDX_W-1:0]  cmd_rs2,
    input  logic [IDX_W-1:0]  cmd_rsz,
    input  logic [DATA_W-1:0] cmd_imm,
    input  logic [ADDR_W-1:0] cmd_ofs,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    output logic [1:0]        req_tag,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_tag,
    input  logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        unit_state
);
    localparam int NPC = 3;
    localparam int NP  = NPC + 1;

    logic [NP-1:0]                 wp_en;
    logic [NP-1:0][IDX_W-1:0]      wp_idx;
    logic [NP-1:0]                 wp_dwe;
    logic [NP-1:0][DATA_W-1:0]     wp_data;
    logic [NP-1:0]                 wp_awe;
    logic [NP-1:0][ADDR_W-1:0]     wp_addr;
    logic [NP-1:0]                 wp_swe;
    logic [NP-1:0][1:0]            wp_stat;
    logic [NREG-1:0][DATA_W-1:0]   rf_data;
    logic [NREG-1:0][ADDR_W-1:0]   rf_addr;
    logic [NREG-1:0][1:0]          rf_stat;
    logic [IDX_W-1:0]              ld_idx, s1_idx, s2_idx;
    logic                          rw_en;
    logic [IDX_W-1:0]              rw_idx;
    logic [DATA_W-1:0]             rw_data;

    mvs_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NREG)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_rd(cmd_rd), .cmd_rs1(cmd_rs1), .cmd_rs2(cmd_rs2), .cmd_rsz(cmd_rsz),
        .cmd_imm(cmd_imm), .cmd_ofs(cmd_ofs),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .unit_state(unit_state),
        .rf_data(rf_data), .rf_addr(rf_addr), .rf_stat(rf_stat),
        .wp_en(wp_en[NPC-1:0]), .wp_idx(wp_idx[NPC-1:0]),
        .wp_dwe(wp_dwe[NPC-1:0]), .wp_data(wp_data[NPC-1:0]),
        .wp_awe(wp_awe[NPC-1:0]), .wp_addr(wp_addr[NPC-1:0]),
        .wp_swe(wp_swe[NPC-1:0]), .wp_stat(wp_stat[NPC-1:0]),
        .ld_idx(ld_idx), .s1_idx(s1_idx), .s2_idx(s2_idx)
    );

    mvs_steer #(.DATA_W(DATA_W), .NREG(NREG)) steer_i (
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .ld_idx(ld_idx), .s1_idx(s1_idx), .s2_idx(s2_idx),
        .wr_en(rw_en), .wr_idx(rw_idx), .wr_data(rw_data)
    );

    // top port: read responses, data plus full status
    assign wp_en[NPC]   = rw_en;
    assign wp_idx[NPC]  = rw_idx;
    assign wp_dwe[NPC]  = 1'b1;
    assign wp_data[NPC] = rw_data;
    assign wp_awe[NPC]  = 1'b0;
    assign wp_addr[NPC] = '0;
    assign wp_swe[NPC]  = 1'b1;
    assign wp_stat[NPC] = mvs_pkg::ST_FULL;

    mvs_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NREG), .NPORT(NP)) rf_i (
        .clk(clk), .rst_n(rst_n),
        .wp_en(wp_en), .wp_idx(wp_idx), .wp_dwe(wp_dwe), .wp_data(wp_data),
        .wp_awe(wp_awe), .wp_addr(wp_addr), .wp_swe(wp_swe), .wp_stat(wp_stat),
        .rf_data(rf_data), .rf_addr(rf_addr), .rf_stat(rf_stat)
    );

endmodule

// File: rtl/mvs_chk.sv
module mvs_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic [1:0]        cmd_op,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic [1:0]        req_tag,
    input logic [1:0]        unit_state
);
    import mvs_pkg::*;

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_wdata)
                                    && $stable(req_write) && $stable(req_tag));

    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unit_state == U_BUSY && cmd_op != OP_LOADI |-> !cmd_ready);

    // R8
    busy_loadi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unit_state == U_BUSY && cmd_op == OP_LOADI |-> cmd_ready);

    // R7
    never_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unit_state != U_OPEN |=> unit_state != U_OPEN);

    // R7
    unit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unit_state != 2'd3);

    // R4
    write_in_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |-> unit_state == U_BUSY && req_tag == TAG_LD);

    // R2
    read_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |-> req_tag != 2'd3);

endmodule

bind mem_vadd_seq mvs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
    .unit_state(unit_state)
);

// File: tb/mem_vadd_seq_tb_top.sv
`timescale 1ns/1ps
module mem_vadd_seq_tb_top;
    import mvs_pkg::*;

    localparam int DW = 16;
    localparam int AW = 16;
    localparam int NR = 8;
    localparam int IW = $clog2(NR);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = OP_LOAD;
    logic [IW-1:0] cmd_rd = '0, cmd_rs1 = '0, cmd_rs2 = '0, cmd_rsz = '0;
    logic [DW-1:0] cmd_imm = '0;
    logic [AW-1:0] cmd_ofs = '0;
    logic          req_valid, req_write;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic [1:0]    req_tag;
    logic          rsp_valid;
    logic [1:0]    rsp_tag;
    logic [DW-1:0] rsp_data;
    logic [1:0]    unit_state;

    mem_vadd_seq #(.DATA_W(DW), .ADDR_W(AW), .NREG(NR)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_rd(cmd_rd), .cmd_rs1(cmd_rs1), .cmd_rs2(cmd_rs2), .cmd_rsz(cmd_rsz),
        .cmd_imm(cmd_imm), .cmd_ofs(cmd_ofs),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .unit_state(unit_state)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // bench-side view of the register file
    logic [AW-1:0] m_base [NR];
    logic [DW-1:0] m_val  [NR];

    // scoreboard of expected requests
    logic          e_wr   [$];
    logic [AW-1:0] e_addr [$];
    logic [DW-1:0] e_data [$];
    logic [1:0]    e_tag  [$];
    string         e_rq   [$];

    // memory model
    logic [DW-1:0] wmem [logic [AW-1:0]];
    int            lat1 = 1, lat2 = 1;
    bit            bp_mode = 1'b0;
    int            p_due [$];
    logic [1:0]    p_tag [$];
    logic [DW-1:0] p_dat [$];

    bit            stalled = 1'b0;
    logic          s_wr;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_data;
    logic [1:0]    s_tag;

    function automatic logic [DW-1:0] mem_rd(logic [AW-1:0] a);
        if (wmem.exists(a)) return wmem[a];
        if (a[AW-1]) return DW'(16'hF000) | DW'(a[7:0]);
        return DW'(a * 3 + 7);
    endfunction

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic push_exp(logic wr, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] t, string rq);
        e_wr.push_back(wr);
        e_addr.push_back(a);
        e_data.push_back(d);
        e_tag.push_back(t);
        e_rq.push_back(rq);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor and memory responder
    always @(negedge clk) begin
        if (!rst_n) begin
            req_ready = 1'b0;
            rsp_valid = 1'b0;
            rsp_tag   = 2'd0;
            rsp_data  = '0;
        end else begin
            req_ready = bp_mode ? ((cyc % 4) == 3) : 1'b1;
            if (stalled) begin
                // R9: a held-off request must not change
                chk(req_valid && req_write == s_wr && req_addr == s_addr &&
                    req_wdata == s_data && req_tag == s_tag,
                    "R9", "stalled request changed addr", req_addr, s_addr);
            end
            if (req_valid && req_ready) begin
                if (e_wr.size() == 0) begin
                    chk(1'b0, "R4", "unexpected request addr", req_addr, 0);
                end else begin
                    automatic logic          xw = e_wr.pop_front();
                    automatic logic [AW-1:0] xa = e_addr.pop_front();
                    automatic logic [DW-1:0] xd = e_data.pop_front();
                    automatic logic [1:0]    xt = e_tag.pop_front();
                    automatic string         xr = e_rq.pop_front();
                    chk(req_write == xw, xr, "request direction", req_write, xw);
                    chk(req_addr == xa, xr, "request address", req_addr, xa);
                    chk(req_tag == xt, xr, "request tag", req_tag, xt);
                    if (xw) chk(req_wdata == xd, xr, "write data", req_wdata, xd);
                end
                if (req_write) begin
                    wmem[req_addr] = req_wdata;
                end else begin
                    p_due.push_back(cyc + (req_tag == TAG_SRC1 ? lat1 :
                                           req_tag == TAG_SRC2 ? lat2 : 2));
                    p_tag.push_back(req_tag);
                    p_dat.push_back(mem_rd(req_addr));
                end
            end
            stalled = req_valid && !req_ready;
            s_wr = req_write; s_addr = req_addr; s_data = req_wdata; s_tag = req_tag;
            rsp_valid = 1'b0;
            for (int i = 0; i < p_due.size(); i++) begin
                if (p_due[i] <= cyc) begin
                    rsp_valid = 1'b1;
                    rsp_tag   = p_tag[i];
                    rsp_data  = p_dat[i];
                    p_due.delete(i);
                    p_tag.delete(i);
                    p_dat.delete(i);
                    break;
                end
            end
        end
    end

    task automatic send(logic [1:0] op, logic [IW-1:0] rd, logic [IW-1:0] r1,
                        logic [IW-1:0] r2, logic [IW-1:0] rz,
                        logic [DW-1:0] imm, logic [AW-1:0] ofs);
        @(negedge clk);
        cmd_op = op; cmd_rd = rd; cmd_rs1 = r1; cmd_rs2 = r2; cmd_rsz = rz;
        cmd_imm = imm; cmd_ofs = ofs; cmd_valid = 1'b1;
        #1;
        while (!cmd_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #0.5;
        cmd_valid = 1'b0;
        cmd_op = OP_LOAD;
    endtask

    task automatic do_loadi(logic [IW-1:0] rd, logic [DW-1:0] v);
        m_val[rd] = v;
        send(OP_LOADI, rd, 0, 0, 0, v, 0);
    endtask

    task automatic do_load(logic [IW-1:0] rd, logic [DW-1:0] hostv, logic [AW-1:0] ofs);
        logic [AW-1:0] a;
        a = AW'(hostv) + ofs;
        m_base[rd] = a;
        push_exp(1'b0, a, '0, TAG_LD, "R2");
        send(OP_LOAD, rd, 0, 0, 0, hostv, ofs);
    endtask

    task automatic exp_add(logic [IW-1:0] rd, logic [IW-1:0] r1, logic [IW-1:0] r2,
                           logic [IW-1:0] rz, string rq);
        for (int i = 0; i < int'(m_val[rz]); i++) begin
            automatic logic [AW-1:0] a1 = m_base[r1] + AW'(i);
            automatic logic [AW-1:0] a2 = m_base[r2] + AW'(i);
            automatic logic [DW-1:0] s  = mem_rd(a1) + mem_rd(a2);
            push_exp(1'b0, a1, '0, TAG_SRC1, rq);
            push_exp(1'b0, a2, '0, TAG_SRC2, rq);
            push_exp(1'b1, m_base[rd] + AW'(i), s, TAG_LD, rq);
        end
    endtask

    task automatic wait_done();
        do begin
            @(negedge clk);
            #1;
        end while (!(e_wr.size() == 0 && p_due.size() == 0 && !rsp_valid && cmd_ready));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1
        chk(unit_state == U_OPEN, "R1", "unit_state after reset", unit_state, U_OPEN);
        chk(req_valid == 1'b0, "R1", "req_valid after reset", req_valid, 0);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);

        // R3: immediate load makes no request
        do_loadi(3'd4, 16'd3);
        #1;
        chk(req_valid == 1'b0, "R3", "request after immediate load", req_valid, 0);
        chk(unit_state == U_OPEN, "R3", "unit_state after immediate load", unit_state, U_OPEN);

        // R2: memory load address and hold-off
        do_load(3'd1, 16'h0000, 16'h0010);
        #1;
        chk(cmd_ready == 1'b0, "R2", "cmd_ready while load pending", cmd_ready, 0);
        chk(req_valid && req_addr == 16'h0010, "R2", "load read address", req_addr, 16'h0010);
        wait_done();
        do_load(3'd2, 16'h0040, 16'h0000);
        wait_done();
        do_load(3'd3, 16'h0100, 16'h0020);
        wait_done();

        // R4 R7 R8: normal add
        exp_add(3'd3, 3'd1, 3'd2, 3'd4, "R4");
        send(OP_ADD, 3'd3, 3'd1, 3'd2, 3'd4, 0, 0);
        #1;
        chk(unit_state == U_BUSY, "R7", "unit_state during add", unit_state, U_BUSY);
        cmd_op = OP_LOAD;
        #0.1;
        chk(cmd_ready == 1'b0, "R8", "cmd_ready for load during add", cmd_ready, 0);
        cmd_op = OP_LOADI;
        #0.1;
        chk(cmd_ready == 1'b1, "R8", "cmd_ready for immediate during add", cmd_ready, 1);
        cmd_op = OP_LOAD;
        do_loadi(3'd6, 16'd9);
        wait_done();
        chk(unit_state == U_FREE, "R7", "unit_state after add", unit_state, U_FREE);

        // R6: zero count
        do_loadi(3'd5, 16'd0);
        send(OP_ADD, 3'd3, 3'd1, 3'd2, 3'd5, 0, 0);
        #1;
        chk(unit_state == U_FREE, "R6", "unit_state after empty add", unit_state, U_FREE);
        chk(cmd_ready == 1'b1, "R6", "cmd_ready after empty add", cmd_ready, 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            #1;
            chk(req_valid == 1'b0, "R6", "request after empty add", req_valid, 0);
        end

        // R10: source-2 answers first
        lat1 = 6; lat2 = 1;
        do_loadi(3'd4, 16'd4);
        exp_add(3'd3, 3'd1, 3'd2, 3'd4, "R10");
        send(OP_ADD, 3'd3, 3'd1, 3'd2, 3'd4, 0, 0);
        wait_done();
        lat1 = 2; lat2 = 3;

        // R9: backpressure on the queue
        bp_mode = 1'b1;
        do_load(3'd1, 16'h0060, 16'h0000);
        wait_done();
        do_loadi(3'd4, 16'd5);
        exp_add(3'd3, 3'd1, 3'd2, 3'd4, "R9");
        send(OP_ADD, 3'd3, 3'd1, 3'd2, 3'd4, 0, 0);
        wait_done();
        bp_mode = 1'b0;

        // R5: sums that wrap
        do_load(3'd1, 16'h8000, 16'h0000);
        wait_done();
        do_load(3'd2, 16'h8010, 16'h0000);
        wait_done();
        do_load(3'd3, 16'h0200, 16'h0000);
        wait_done();
        do_loadi(3'd4, 16'd3);
        chk(DW'(mem_rd(16'h8000) + mem_rd(16'h8010)) < mem_rd(16'h8000), "R5",
            "model sum wraps", mem_rd(16'h8000) + mem_rd(16'h8010), 0);
        exp_add(3'd3, 3'd1, 3'd2, 3'd4, "R5");
        send(OP_ADD, 3'd3, 3'd1, 3'd2, 3'd4, 0, 0);
        wait_done();
        chk(wmem.exists(16'h0200) && wmem[16'h0200] == 16'hE010, "R5",
            "wrapped sum in memory", wmem[16'h0200], 16'hE010);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule